// File: doc/BRIEF.md
# Root-Port Interrupt Decode and Mask Controller

This block collects single-cycle event pulses raised by a PCIe root-port bridge and records each one in its own bit of a 32-bit sticky status register. The events are link loss, end-to-end CRC failure, streaming faults, hot reset, configuration completion status, configuration timeout, received correctable, non-fatal and fatal error messages, legacy INTx and MSI arrival, and faults on the bridge's slave and master bus sides. A second 32-bit register holds one enable per event. The block drives one level interrupt line, which is raised when any recorded event is also enabled.

Software reads and writes both registers over a plain register bus with a read strobe, a write strobe, a byte address and 32-bit data. Status bits are cleared by writing ones to them. Recording does not depend on the enables, so software can poll events that it keeps off the interrupt line. The set of implemented bits is fixed by a parameter. Every other bit position reads as zero and cannot be set.

Top module: `irqdm_ctrl`

## Requirements
- R1: A one-cycle pulse on an event input sets its status bit at the clock edge that samples it. The bit positions are: link loss 0, streaming fault 2, hot reset 3, configuration timeout 8, correctable message 9, non-fatal message 10, fatal message 11, INTx 16, MSI 17, slave faults 20..25 (unsupported request, unexpected completion, completion timeout, poisoned data, completer abort, illegal burst), and master faults 26..28 (decode error, slave error, poisoned data).
- R2: The 3-bit configuration completion status input maps onto status bits 7:5 (input bit k onto status bit 5+k). Each bit is sticky on its own.
- R3: Status bits latch whether or not their enable bit is set.
- R4: A write to the status register (byte offset 0x0) clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R5: When an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R6: Only the bits of 0x1FF30FED are implemented. All other bits of both registers read 0 and ignore writes and events. With this map the end-to-end CRC event (position 1) therefore never shows.
- R7: The interrupt output is registered. It goes high one cycle after the AND of status and enable becomes non-zero, and goes low one cycle after that AND becomes zero.
- R8: After reset the status register, the enable register, the read data and the interrupt output are all zero.
- R9: A read strobe at offset 0x0 (status) or 0x4 (enable) returns that register's value on the read-data port one cycle later. Any other offset returns zero.
- R10: While the enable register is all zeros, the interrupt output stays low, no matter which status bits are pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_link_down | input | 1 | Link lost pulse |
| ev_ecrc | input | 1 | End-to-end CRC failure pulse |
| ev_stream | input | 1 | Streaming fault pulse |
| ev_hot_reset | input | 1 | Hot reset pulse |
| ev_cfg_status | input | 3 | Configuration completion status pulses |
| ev_cfg_timeout | input | 1 | Configuration access timeout pulse |
| ev_msg_corr | input | 1 | Correctable error message pulse |
| ev_msg_nonfatal | input | 1 | Non-fatal error message pulse |
| ev_msg_fatal | input | 1 | Fatal error message pulse |
| ev_intx | input | 1 | Legacy interrupt arrival pulse |
| ev_msi | input | 1 | MSI arrival pulse |
| ev_slv_fault | input | 6 | Slave-side fault pulses |
| ev_mst_fault | input | 3 | Master-side fault pulses |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read strobe |
| irq | output | 1 | Level interrupt output |

## Verification
A pulse sampled at edge N sets its status bit at edge N, and the interrupt line follows at edge N+1. A write clears or sets its register at its own edge, and read data appears at the edge that samples the strobe. The bench drives every input just after a falling edge and samples just after the next falling edge. It checks the interrupt at both the falling edge after the status change and the one after that, so a missing or an extra register stage is caught. Status values are read back over the register bus after each stimulus, and the bench compares them with a model built only from the bit map above.

// File: rtl/irqdm_pkg.sv
package irqdm_pkg;
  localparam int unsigned REG_W = 32;

  // status bit positions
  localparam int unsigned POS_LINK_DOWN   = 0;
  localparam int unsigned POS_ECRC        = 1;
  localparam int unsigned POS_STREAM      = 2;
  localparam int unsigned POS_HOT_RESET   = 3;
  localparam int unsigned POS_CPL_LSB     = 5;
  localparam int unsigned CPL_W           = 3;
  localparam int unsigned POS_CFG_TIMEOUT = 8;
  localparam int unsigned POS_MSG_CORR    = 9;
  localparam int unsigned POS_MSG_NONFAT  = 10;
  localparam int unsigned POS_MSG_FATAL   = 11;
  localparam int unsigned POS_INTX        = 16;
  localparam int unsigned POS_MSI         = 17;
  localparam int unsigned POS_SLV_LSB     = 20;
  localparam int unsigned SLV_W           = 6;
  localparam int unsigned POS_MST_LSB     = 26;
  localparam int unsigned MST_W           = 3;

  localparam logic [REG_W-1:0] IMPL_MASK_DEFAULT = 32'h1FF3_0FED;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_STAT = 2'd1,
    SEL_ENAB = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/irqdm_event_map.sv
module irqdm_event_map
  import irqdm_pkg::*;
#(
  parameter logic [REG_W-1:0] IMPL_MASK = IMPL_MASK_DEFAULT
) (
  input  logic             ev_link_down,
  input  logic             ev_ecrc,
  input  logic             ev_stream,
  input  logic             ev_hot_reset,
  input  logic [CPL_W-1:0] ev_cfg_status,
  input  logic             ev_cfg_timeout,
  input  logic             ev_msg_corr,
  input  logic             ev_msg_nonfatal,
  input  logic             ev_msg_fatal,
  input  logic             ev_intx,
  input  logic             ev_msi,
  input  logic [SLV_W-1:0] ev_slv_fault,
  input  logic [MST_W-1:0] ev_mst_fault,
  output logic [REG_W-1:0] set_o
);
  logic [REG_W-1:0] raw;
  logic [REG_W-1:0] single_bits;
  logic [REG_W-1:0] field_bits;

  always_comb begin
    single_bits                  = '0;
    single_bits[POS_LINK_DOWN]   = ev_link_down;
    single_bits[POS_ECRC]        = ev_ecrc;
    single_bits[POS_STREAM]      = ev_stream;
    single_bits[POS_HOT_RESET]   = ev_hot_reset;
    single_bits[POS_CFG_TIMEOUT] = ev_cfg_timeout;
    single_bits[POS_MSG_CORR]    = ev_msg_corr;
    single_bits[POS_MSG_NONFAT]  = ev_msg_nonfatal;
    single_bits[POS_MSG_FATAL]   = ev_msg_fatal;
    single_bits[POS_INTX]        = ev_intx;
    single_bits[POS_MSI]         = ev_msi;
  end

  // multi-bit fields placed by generate loops
  for (genvar gi = 0; gi < REG_W; gi++) begin : g_field
    if (gi >= POS_CPL_LSB && gi < POS_CPL_LSB + CPL_W) begin : g_cpl
      assign field_bits[gi] = ev_cfg_status[gi - POS_CPL_LSB];
    end else if (gi >= POS_SLV_LSB && gi < POS_SLV_LSB + SLV_W) begin : g_slv
      assign field_bits[gi] = ev_slv_fault[gi - POS_SLV_LSB];
    end else if (gi >= POS_MST_LSB && gi < POS_MST_LSB + MST_W) begin : g_mst
      assign field_bits[gi] = ev_mst_fault[gi - POS_MST_LSB];
    end else begin : g_none
      assign field_bits[gi] = 1'b0;
    end
  end

  assign raw   = single_bits | field_bits;
  assign set_o = raw & IMPL_MASK;
endmodule

// File: rtl/irqdm_sticky_reg.sv
module irqdm_sticky_reg
  import irqdm_pkg::*;
#(
  parameter logic [REG_W-1:0] IMPL_MASK = IMPL_MASK_DEFAULT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] set_i,
  input  logic [REG_W-1:0] clr_i,
  output logic [REG_W-1:0] stat_q
);
  logic [REG_W-1:0] stat_d;
  logic             upd_en;

  // set has priority over clear so no event is lost
  always_comb begin
    stat_d = ((stat_q & ~clr_i) | set_i) & IMPL_MASK;
    upd_en = (|set_i) | (|clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else if (upd_en) begin
      stat_q <= stat_d;
    end
  end

  // R5
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_i & IMPL_MASK) != '0) |=> ((stat_q & $past(set_i & IMPL_MASK)) == $past(set_i & IMPL_MASK)));

  // R4
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i != '0) |=> ((stat_q & $past(clr_i) & ~$past(set_i)) == '0));

  // R4
  w1c_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~$past(set_i)) == ($past(stat_q) & ~$past(clr_i) & ~$past(set_i))));

  // R6
  stat_impl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q & ~IMPL_MASK) == '0);
endmodule

// File: rtl/irqdm_enable_reg.sv
module irqdm_enable_reg
  import irqdm_pkg::*;
#(
  parameter logic [REG_W-1:0] IMPL_MASK = IMPL_MASK_DEFAULT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] enab_q
);
  logic [REG_W-1:0] enab_d;

  always_comb enab_d = wdata & IMPL_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enab_q <= '0;
    end else if (wr_en) begin
      enab_q <= enab_d;
    end
  end

  // R6
  enab_impl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enab_q & ~IMPL_MASK) == '0);

  // R6
  enab_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(enab_q));
endmodule

// File: rtl/irqdm_irq_gen.sv
module irqdm_irq_gen
  import irqdm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] stat_i,
  input  logic [REG_W-1:0] enab_i,
  output logic             irq_o
);
  logic irq_d;

  always_comb irq_d = |(stat_i & enab_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o <= 1'b0;
    end else begin
      irq_o <= irq_d;
    end
  end

  // R7
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == (($past(stat_i) & $past(enab_i)) != '0)));

  // R10
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enab_i == '0) |=> !irq_o);
endmodule

// File: rtl/irqdm_ctrl.sv
module irqdm_ctrl
  import irqdm_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 4,
  parameter logic [REG_W-1:0]  IMPL_MASK = IMPL_MASK_DEFAULT,
  parameter logic [ADDR_W-1:0] STAT_OFS  = 'h0,
  parameter logic [ADDR_W-1:0] ENAB_OFS  = 'h4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_link_down,
  input  logic              ev_ecrc,
  input  logic              ev_stream,
  input  logic              ev_hot_reset,
  input  logic [2:0]        ev_cfg_status,
  input  logic              ev_cfg_timeout,
  input  logic              ev_msg_corr,
  input  logic              ev_msg_nonfatal,
  input  logic              ev_msg_fatal,
  input  logic              ev_intx,
  input  logic              ev_msi,
  input  logic [5:0]        ev_slv_fault,
  input  logic [2:0]        ev_mst_fault,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  logic [REG_W-1:0] set_vec;
  logic [REG_W-1:0] clr_vec;
  logic [REG_W-1:0] stat_q;
  logic [REG_W-1:0] enab_q;
  logic             enab_wr;
  reg_sel_e         sel;
  logic [REG_W-1:0] rdata_d;
  logic [REG_W-1:0] rdata_q;

  always_comb begin
    if (bus_addr == STAT_OFS)      sel = SEL_STAT;
    else if (bus_addr == ENAB_OFS) sel = SEL_ENAB;
    else                           sel = SEL_NONE;
  end

  always_comb begin
    clr_vec = (bus_wr && sel == SEL_STAT) ? (bus_wdata & IMPL_MASK) : '0;
    enab_wr = bus_wr && (sel == SEL_ENAB);
  end

  irqdm_event_map #(.IMPL_MASK(IMPL_MASK)) u_map (
    .ev_link_down   (ev_link_down),
    .ev_ecrc        (ev_ecrc),
    .ev_stream      (ev_stream),
    .ev_hot_reset   (ev_hot_reset),
    .ev_cfg_status  (ev_cfg_status),
    .ev_cfg_timeout (ev_cfg_timeout),
    .ev_msg_corr    (ev_msg_corr),
    .ev_msg_nonfatal(ev_msg_nonfatal),
    .ev_msg_fatal   (ev_msg_fatal),
    .ev_intx        (ev_intx),
    .ev_msi         (ev_msi),
    .ev_slv_fault   (ev_slv_fault),
    .ev_mst_fault   (ev_mst_fault),
    .set_o          (set_vec)
  );

  irqdm_sticky_reg #(.IMPL_MASK(IMPL_MASK)) u_stat (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (set_vec),
    .clr_i (clr_vec),
    .stat_q(stat_q)
  );

  irqdm_enable_reg #(.IMPL_MASK(IMPL_MASK)) u_enab (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (enab_wr),
    .wdata (bus_wdata),
    .enab_q(enab_q)
  );

  irqdm_irq_gen u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .stat_i(stat_q),
    .enab_i(enab_q),
    .irq_o (irq)
  );

  always_comb begin
    unique case (sel)
      SEL_STAT: rdata_d = stat_q;
      SEL_ENAB: rdata_d = enab_q;
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;

  // R9
  rd_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == STAT_OFS) |=> (bus_rdata == $past(stat_q)));

  // R9
  rd_enab_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ENAB_OFS) |=> (bus_rdata == $past(enab_q)));

  // R9
  rd_hole_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr != STAT_OFS && bus_addr != ENAB_OFS) |=> (bus_rdata == '0));
endmodule

// File: tb/irqdm_ctrl_tb.sv
module irqdm_ctrl_tb;
  localparam logic [31:0] IMPL = 32'h1FF3_0FED;
  localparam logic [3:0]  A_ST = 4'h0;
  localparam logic [3:0]  A_EN = 4'h4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] ev_raw;
  logic        bus_wr, bus_rd;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  irqdm_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .ev_link_down(ev_raw[0]), .ev_ecrc(ev_raw[1]), .ev_stream(ev_raw[2]),
    .ev_hot_reset(ev_raw[3]), .ev_cfg_status(ev_raw[7:5]),
    .ev_cfg_timeout(ev_raw[8]), .ev_msg_corr(ev_raw[9]),
    .ev_msg_nonfatal(ev_raw[10]), .ev_msg_fatal(ev_raw[11]),
    .ev_intx(ev_raw[16]), .ev_msi(ev_raw[17]),
    .ev_slv_fault(ev_raw[25:20]), .ev_mst_fault(ev_raw[28:26]),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic pulse(input logic [31:0] v);
    ev_raw = v;
    @(negedge clk);
    ev_raw = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R8 irq", {31'b0, irq}, 32'h0);
    chk("R8 rdata", bus_rdata, 32'h0);
    rd(A_ST, d); chk("R8 status", d, 32'h0);
    rd(A_EN, d); chk("R8 enable", d, 32'h0);
  endtask

  task automatic t_each_bit();
    logic [31:0] d;
    for (int p = 0; p < 29; p++) begin
      pulse(32'h1 << p);
      rd(A_ST, d);
      if (p >= 5 && p <= 7) chk("R2 status field", d, (32'h1 << p) & IMPL);
      else if (p == 1)      chk("R6 crc bit unimplemented", d, 32'h0);
      else                  chk("R1 R3 event latch", d, (32'h1 << p) & IMPL);
      chk("R10 irq masked", {31'b0, irq}, 32'h0);
      wr(A_ST, 32'h1 << p);
      rd(A_ST, d);
      chk("R4 w1c single", d, 32'h0);
    end
  endtask

  task automatic t_irq_latency();
    logic [31:0] d;
    wr(A_EN, 32'h0001_0000);
    pulse(32'h0001_0000);
    chk("R7 irq not early", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R7 irq rises", {31'b0, irq}, 32'h1);
    wr(A_ST, 32'h0001_0000);
    chk("R7 irq still high", {31'b0, irq}, 32'h1);
    @(negedge clk);
    chk("R7 irq falls", {31'b0, irq}, 32'h0);
    rd(A_ST, d); chk("R4 cleared", d, 32'h0);
    wr(A_EN, 32'h0);
  endtask

  task automatic t_w1c_partial();
    logic [31:0] d;
    pulse(32'h0C00_0F0D);
    wr(A_ST, 32'h0);
    rd(A_ST, d); chk("R4 zero write keeps", d, 32'h0C00_0F0D);
    wr(A_ST, 32'h0800_0104);
    rd(A_ST, d); chk("R4 partial clear", d, 32'h0400_0E09);
    wr(A_ST, 32'hFFFF_FFFF);
    rd(A_ST, d); chk("R4 full clear", d, 32'h0);
  endtask

  task automatic t_race();
    logic [31:0] d;
    pulse(32'h0002_0200);
    ev_raw = 32'h0002_0000;
    bus_wr = 1'b1; bus_addr = A_ST; bus_wdata = 32'h0002_0200;
    @(negedge clk);
    ev_raw = '0; bus_wr = 1'b0; bus_wdata = '0;
    rd(A_ST, d); chk("R5 set beats clear", d, 32'h0002_0000);
    wr(A_ST, 32'hFFFF_FFFF);
  endtask

  task automatic t_regmap();
    logic [31:0] d;
    wr(A_EN, 32'hFFFF_FFFF);
    rd(A_EN, d); chk("R6 enable implemented bits", d, IMPL);
    rd(4'h8, d); chk("R9 hole reads zero", d, 32'h0);
    wr(4'h8, 32'h0);
    rd(A_EN, d); chk("R9 hole write ignored", d, IMPL);
    rd(A_ST, d); chk("R9 status read", d, 32'h0);
    wr(A_EN, 32'h0);
  endtask

  task automatic t_mask_zero();
    logic [31:0] d;
    pulse(32'h1FF3_0FFF);
    rd(A_ST, d); chk("R3 all latched", d, IMPL);
    repeat (3) @(negedge clk);
    chk("R10 irq low with zero enable", {31'b0, irq}, 32'h0);
    wr(A_EN, 32'h1000_0000);
    chk("R7 irq one cycle after enable", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R7 irq after enable", {31'b0, irq}, 32'h1);
    wr(A_EN, 32'h0);
    @(negedge clk);
    chk("R10 irq off after disable", {31'b0, irq}, 32'h0);
    wr(A_ST, 32'hFFFF_FFFF);
  endtask

  initial begin
    rst_n = 1'b0; ev_raw = '0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_each_bit();
    t_irq_latency();
    t_w1c_partial();
    t_race();
    t_regmap();
    t_mask_zero();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule